// File: doc/BRIEF.md
# Framed Serial Receiver with Sticky Error Flags

This block is the receiving side of a synchronous serial port in which every word is announced by a frame-sync pulse. Incoming bits arrive on a serial data pin together with a one-cycle bit-enable strobe, and all of them are taken in a single system clock domain. A frame-sync strobe seen together with a bit strobe marks the most significant bit of a new word. Once the last bit has arrived, the assembled word moves into a single-entry holding buffer. The host empties that buffer with a one-cycle read strobe.

Three faults are caught and latched as sticky status bits:
- a frame sync that arrives while a word is still being assembled;
- a host read of an empty buffer;
- an overrun, where a new word is complete but the buffer still holds an unread one.

On overrun the receiver stalls. It keeps the finished word in its shift register and discards all serial traffic. When the host reads the buffer, the stalled word moves into the buffer, and reception restarts only at the next frame sync. Each status bit can pull an active-low interrupt line if its enable is set, and the host clears a bit by writing one to it.

The control FSM has three states:
- `RX_IDLE`: waiting for a frame sync.
- `RX_SHIFT`: assembling a word.
- `RX_STALL`: overrun, receiver frozen.

It has five transitions:
- `IDLE→SHIFT`: frame sync with a bit strobe.
- `SHIFT→IDLE`: last bit arrives and the buffer is free or is read in that cycle.
- `SHIFT→STALL`: last bit arrives and the buffer holds an unread word.
- `STALL→IDLE`: host read.
- `any→IDLE`: the receiver enable is low.

Top module: `frame_rx_port`

## Requirements
- R1: While `rst_n` is low and right after it, `buf_rdy`=0, `ovr_full`=0, `err_sts`=0 and `irq_n`=1.
- R2: A word starts only on a cycle with `bit_en`=1 and `fsync`=1, where `sdata` is the MSB. The next W-1 cycles with `bit_en`=1 supply the remaining bits in MSB-first order. Cycles with `bit_en`=0, and bits that arrive in idle without `fsync`, are ignored.
- R3: When the last bit arrives and the buffer is empty, or is read in that same cycle, `buf_data` holds the word and `buf_rdy`=1 from the next cycle on, with no overrun.
- R4: A `buf_rd` pulse while `buf_rdy`=1 returns the word on `buf_data` and clears `buf_rdy` in the next cycle, unless a new word lands in that same cycle.
- R5: A `fsync` with `bit_en` while a word is mid-reception sets `err_sts[0]`. Framing is unchanged and that bit is taken as data.
- R6: A `buf_rd` while `buf_rdy`=0 sets `err_sts[1]`.
- R7: If a word completes while the buffer holds an unread word and no read occurs in that cycle, `ovr_full` and `err_sts[2]` become 1 in the next cycle, and `buf_data` keeps the old word.
- R8: While `ovr_full`=1, serial bits and `fsync` are ignored and raise no sync error. A `buf_rd` returns the old word. From the next cycle, `buf_data` is the stalled word, `buf_rdy` stays 1 and `ovr_full` is 0. The next word then needs a new `fsync`.
- R9: `rx_on`=0 aborts any partial word and clears `buf_rdy` and `ovr_full` in the next cycle, while `err_sts` keeps its value. After `rx_on` returns, reception waits for a new `fsync`.
- R10: A cycle with `sts_w1c_wr`=1 clears each `err_sts` bit whose `sts_w1c` bit is 1. An error event in that same cycle keeps its bit set.
- R11: `irq_n` is 0 exactly when some bit of `err_sts & irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global active-low reset |
| rx_on | input | 1 | Receiver enable; low holds the receiver in reset |
| bit_en | input | 1 | Serial bit strobe |
| fsync | input | 1 | Frame-sync strobe |
| sdata | input | 1 | Serial data bit |
| buf_rd | input | 1 | Host read strobe for the buffer |
| buf_data | output | W | Buffered word |
| buf_rdy | output | 1 | Buffer holds an unread word |
| ovr_full | output | 1 | Overrun stall active |
| sts_w1c_wr | input | 1 | Status write-one-to-clear strobe |
| sts_w1c | input | 3 | Bits to clear: [0] sync, [1] underflow, [2] overrun |
| irq_en | input | 3 | Interrupt enable per status bit |
| err_sts | output | 3 | Sticky status: [0] sync, [1] underflow, [2] overrun |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Words are sent in several ways:
- With bit strobes back to back, and with idle gaps between strobes. This separates bit counting from clock counting.
- Preceded by serial noise that has no frame sync. This shows that framing keys on the sync strobe alone.
- With a sync strobe inside the word. This checks that such a strobe only raises a flag and does not restart the word.

Buffer reads are placed:
- before a word completes, which is the normal handoff;
- in the completion cycle, where the read must prevent an overrun;
- after it, where an overrun and a stall must follow.

A random mix of frames, reads, clears and enable drops is then compared every cycle against a behavioural model.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_STALL = 2'd2
    } rx_state_e;

    localparam int unsigned ERR_SYNC = 0;
    localparam int unsigned ERR_UNDF = 1;
    localparam int unsigned ERR_OVF  = 2;
    localparam int unsigned N_ERR    = 3;
endpackage

// File: rtl/sfr_shifter.sv
module sfr_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         shift,
    input  logic         sdata,
    output logic [W-1:0] word,
    output logic [W-1:0] next_word,
    output logic         at_last
);
    localparam int unsigned CW = $clog2(W);

    logic [CW-1:0] cnt;

    assign next_word = {word[W-2:0], sdata};
    assign at_last   = (cnt == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (start) begin
            word <= next_word;
            cnt  <= CW'(1);
        end else if (shift) begin
            word <= next_word;
            cnt  <= at_last ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sfr_rxbuf.sv
module sfr_rxbuf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            if (load) begin
                data <= din;
            end
            if (clr) begin
                valid <= 1'b0;
            end else if (load) begin
                valid <= 1'b1;
            end else if (rd) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sfr_errstat.sv
module sfr_errstat #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] sts,
    output logic         irq_n
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sts[k] <= 1'b0;
            end else if (set[k]) begin
                sts[k] <= 1'b1;
            end else if (clr_wr && clr_mask[k]) begin
                sts[k] <= 1'b0;
            end
        end
    end

    assign irq_n = ~|(sts & irq_en);
endmodule

// File: rtl/sfr_fsm.sv
module sfr_fsm
    import sfr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_on,
    input  logic      bit_en,
    input  logic      fsync,
    input  logic      at_last,
    input  logic      buf_valid,
    input  logic      buf_rd,
    output rx_state_e state,
    output logic      start,
    output logic      shift,
    output logic      push_live,
    output logic      push_held,
    output logic      ev_sync,
    output logic      ev_ovf
);
    rx_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else if (!rx_on) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt       = state;
        start     = 1'b0;
        shift     = 1'b0;
        push_live = 1'b0;
        push_held = 1'b0;
        ev_sync   = 1'b0;
        ev_ovf    = 1'b0;
        if (rx_on) begin
            unique case (state)
                RX_IDLE: begin
                    if (bit_en && fsync) begin
                        start = 1'b1;
                        nxt   = RX_SHIFT;
                    end
                end
                RX_SHIFT: begin
                    if (bit_en) begin
                        shift   = 1'b1;
                        ev_sync = fsync;
                        if (at_last) begin
                            if (!buf_valid || buf_rd) begin
                                push_live = 1'b1;
                                nxt       = RX_IDLE;
                            end else begin
                                ev_ovf = 1'b1;
                                nxt    = RX_STALL;
                            end
                        end
                    end
                end
                RX_STALL: begin
                    if (buf_rd) begin
                        push_held = 1'b1;
                        nxt       = RX_IDLE;
                    end
                end
                default: nxt = RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame_rx_port.sv
module frame_rx_port
    import sfr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_on,
    input  logic             bit_en,
    input  logic             fsync,
    input  logic             sdata,
    input  logic             buf_rd,
    output logic [W-1:0]     buf_data,
    output logic             buf_rdy,
    output logic             ovr_full,
    input  logic             sts_w1c_wr,
    input  logic [N_ERR-1:0] sts_w1c,
    input  logic [N_ERR-1:0] irq_en,
    output logic [N_ERR-1:0] err_sts,
    output logic             irq_n
);
    rx_state_e        state;
    logic             start, shift, push_live, push_held, ev_sync, ev_ovf;
    logic             at_last;
    logic [W-1:0]     word, next_word, buf_din;
    logic [N_ERR-1:0] ev_set;

    sfr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_on     (rx_on),
        .bit_en    (bit_en),
        .fsync     (fsync),
        .at_last   (at_last),
        .buf_valid (buf_rdy),
        .buf_rd    (buf_rd),
        .state     (state),
        .start     (start),
        .shift     (shift),
        .push_live (push_live),
        .push_held (push_held),
        .ev_sync   (ev_sync),
        .ev_ovf    (ev_ovf)
    );

    sfr_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!rx_on),
        .start     (start),
        .shift     (shift),
        .sdata     (sdata),
        .word      (word),
        .next_word (next_word),
        .at_last   (at_last)
    );

    assign buf_din = push_held ? word : next_word;

    sfr_rxbuf #(.W(W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rx_on),
        .load  (push_live || push_held),
        .din   (buf_din),
        .rd    (buf_rd),
        .data  (buf_data),
        .valid (buf_rdy)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[ERR_SYNC] = ev_sync;
        ev_set[ERR_UNDF] = buf_rd && !buf_rdy;
        ev_set[ERR_OVF]  = ev_ovf;
    end

    sfr_errstat #(.N(N_ERR)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (ev_set),
        .clr_wr   (sts_w1c_wr),
        .clr_mask (sts_w1c),
        .irq_en   (irq_en),
        .sts      (err_sts),
        .irq_n    (irq_n)
    );

    assign ovr_full = (state == RX_STALL);
endmodule

// File: rtl/frame_rx_port_chk.sv
module frame_rx_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_on,
    input logic         buf_rd,
    input logic [W-1:0] buf_data,
    input logic         buf_rdy,
    input logic         ovr_full,
    input logic         sts_w1c_wr,
    input logic [2:0]   sts_w1c,
    input logic [2:0]   irq_en,
    input logic [2:0]   err_sts,
    input logic         irq_n
);
    a_r7_full_implies_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_full |-> buf_rdy);

    a_r6_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !buf_rdy) |=> err_sts[1]);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_full && !buf_rd && rx_on) |=> (ovr_full && $stable(buf_data)));

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> (!buf_rdy && !ovr_full));

    a_r11_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_sts & irq_en) == 3'b000) |-> irq_n);

    for (genvar k = 0; k < 3; k++) begin : g_w1c
        a_r10_fall_needs_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_sts[k]) |-> $past(sts_w1c_wr && sts_w1c[k]));
    end
endmodule

bind frame_rx_port frame_rx_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_on      (rx_on),
    .buf_rd     (buf_rd),
    .buf_data   (buf_data),
    .buf_rdy    (buf_rdy),
    .ovr_full   (ovr_full),
    .sts_w1c_wr (sts_w1c_wr),
    .sts_w1c    (sts_w1c),
    .irq_en     (irq_en),
    .err_sts    (err_sts),
    .irq_n      (irq_n)
);

// File: tb/test_frame_rx_port.sv
module test_frame_rx_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, rx_on, bit_en, fsync, sdata, buf_rd, sts_w1c_wr;
    logic [2:0]   sts_w1c, irq_en, err_sts;
    logic [W-1:0] buf_data;
    logic         buf_rdy, ovr_full, irq_n;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] v;

    frame_rx_port #(.W(W)) i_frame_rx_port (
        .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .bit_en(bit_en), .fsync(fsync),
        .sdata(sdata), .buf_rd(buf_rd), .buf_data(buf_data), .buf_rdy(buf_rdy),
        .ovr_full(ovr_full), .sts_w1c_wr(sts_w1c_wr), .sts_w1c(sts_w1c),
        .irq_en(irq_en), .err_sts(err_sts), .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 collecting, 2 stalled
    int           m_state, m_cnt;
    logic [W-1:0] m_word, m_buf;
    bit           m_valid;
    logic [2:0]   m_sts;

    always @(posedge clk) begin
        logic [2:0] ev;
        bit push;
        ev = 3'b000;
        push = 0;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_word = '0; m_buf = '0; m_valid = 0; m_sts = 3'b000;
        end else begin
            if (buf_rd && !m_valid) ev[1] = 1'b1;
            if (!rx_on) begin
                m_state = 0; m_cnt = 0; m_valid = 0;
            end else begin
                case (m_state)
                    0: if (bit_en && fsync) begin
                        m_word = {m_word[W-2:0], sdata}; m_cnt = 1; m_state = 1;
                    end
                    1: if (bit_en) begin
                        if (fsync) ev[0] = 1'b1;
                        m_word = {m_word[W-2:0], sdata};
                        if (m_cnt == W - 1) begin
                            m_cnt = 0;
                            if (!m_valid || buf_rd) begin
                                m_buf = m_word; push = 1; m_state = 0;
                            end else begin
                                ev[2] = 1'b1; m_state = 2;
                            end
                        end else m_cnt++;
                    end
                    default: if (buf_rd) begin
                        m_buf = m_word; push = 1; m_state = 0;
                    end
                endcase
                if (push) m_valid = 1;
                else if (buf_rd) m_valid = 0;
            end
            m_sts = (m_sts & ~(sts_w1c_wr ? sts_w1c : 3'b000)) | ev;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(buf_rdy === m_valid, "R3/R4 model buf_rdy", 32'(buf_rdy), 32'(m_valid));
            if (m_valid) chk(buf_data === m_buf, "R3 model buf_data", 32'(buf_data), 32'(m_buf));
            chk(ovr_full === (m_state == 2), "R7/R8 model ovr_full", 32'(ovr_full), 32'(m_state == 2));
            chk(err_sts === m_sts, "R5/R6/R10 model err_sts", 32'(err_sts), 32'(m_sts));
            chk(irq_n === ~|(m_sts & irq_en), "R11 model irq_n", 32'(irq_n), 32'(~|(m_sts & irq_en)));
        end
    end

    task automatic quiet();
        bit_en = 0; fsync = 0; buf_rd = 0; sts_w1c_wr = 0;
    endtask

    task automatic send(input logic [W-1:0] d, input int mid, input int gap, input bit rd_last);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            bit_en = 1; fsync = (i == 0) || (i == mid); sdata = d[W-1-i];
            buf_rd = rd_last && (i == W - 1);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk); quiet(); sdata = ~sdata;
            end
        end
        @(negedge clk); quiet();
    endtask

    task automatic noise(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_en = 1; fsync = 0; sdata = 1'($urandom);
        end
        @(negedge clk); quiet();
    endtask

    task automatic rd_buf(output logic [W-1:0] val);
        @(negedge clk); val = buf_data; buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic w1c(input logic [2:0] m);
        @(negedge clk); sts_w1c_wr = 1; sts_w1c = m;
        @(negedge clk); sts_w1c_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; rx_on = 1; sdata = 0; sts_w1c = 3'b000; irq_en = 3'b000; quiet();
        repeat (3) @(negedge clk);
        chk(buf_rdy == 0 && ovr_full == 0, "R1 reset rdy/full", {buf_rdy, ovr_full}, 0);
        chk(err_sts == 0 && irq_n == 1, "R1 reset sts/irq", {err_sts, irq_n}, 1);
        rst_n = 1;
        @(negedge clk);
        chk(buf_rdy == 0 && err_sts == 0, "R1 after reset", {buf_rdy, err_sts}, 0);

        noise(10);
        chk(buf_rdy == 0, "R2 no word without fsync", buf_rdy, 0);
        send(8'hA5, -1, 2, 0);
        chk(buf_rdy == 1 && buf_data == 8'hA5, "R2/R3 gapped word", buf_data, 8'hA5);
        rd_buf(v);
        chk(v == 8'hA5, "R4 read data", v, 8'hA5);
        chk(buf_rdy == 0, "R4 rdy cleared", buf_rdy, 0);

        rd_buf(v);
        chk(err_sts == 3'b010, "R6 underflow", err_sts, 3'b010);
        @(negedge clk); irq_en = 3'b010;
        @(negedge clk);
        chk(irq_n == 0, "R11 enabled irq", irq_n, 0);
        irq_en = 3'b101;
        @(negedge clk);
        chk(irq_n == 1, "R11 masked irq", irq_n, 1);
        irq_en = 3'b010;
        w1c(3'b010);
        chk(err_sts == 0 && irq_n == 1, "R10 w1c clears", {err_sts, irq_n}, 1);

        @(negedge clk); buf_rd = 1; sts_w1c_wr = 1; sts_w1c = 3'b010;
        @(negedge clk); quiet();
        chk(err_sts[1] == 1, "R10 set beats clear", err_sts, 3'b010);
        w1c(3'b010);

        send(8'h3C, 3, 0, 0);
        chk(buf_data == 8'h3C, "R5 framing kept", buf_data, 8'h3C);
        chk(err_sts == 3'b001, "R5 sync flag", err_sts, 3'b001);
        w1c(3'b001);

        send(8'h81, -1, 1, 0);
        chk(ovr_full == 1 && err_sts == 3'b100, "R7 overrun", {ovr_full, err_sts}, 4'hC);
        chk(buf_data == 8'h3C && buf_rdy == 1, "R7 old word kept", buf_data, 8'h3C);
        send(8'hFF, 2, 0, 0);
        chk(err_sts == 3'b100 && ovr_full == 1, "R8 stalled ignores", {ovr_full, err_sts}, 4'hC);
        chk(buf_data == 8'h3C, "R8 stall data", buf_data, 8'h3C);
        rd_buf(v);
        chk(v == 8'h3C, "R8 read old", v, 8'h3C);
        chk(buf_data == 8'h81 && buf_rdy == 1 && ovr_full == 0, "R8 held word moves", buf_data, 8'h81);
        noise(12);
        rd_buf(v);
        chk(v == 8'h81 && buf_rdy == 0, "R8 needs new fsync", {buf_rdy, v}, 8'h81);
        w1c(3'b111);

        send(8'h11, -1, 0, 0);
        send(8'h22, -1, 0, 1);
        chk(ovr_full == 0 && err_sts == 0, "R3 read in completion cycle", {ovr_full, err_sts}, 0);
        chk(buf_data == 8'h22 && buf_rdy == 1, "R3 new word", buf_data, 8'h22);
        rd_buf(v);

        send(8'h55, -1, 0, 0);
        @(negedge clk); bit_en = 1; fsync = 1; sdata = 1;
        @(negedge clk); fsync = 0;
        @(negedge clk); quiet(); rx_on = 0;
        @(negedge clk); rx_on = 1;
        chk(buf_rdy == 0 && ovr_full == 0, "R9 disable clears", {buf_rdy, ovr_full}, 0);
        noise(6);
        chk(buf_rdy == 0, "R9 waits for fsync", buf_rdy, 0);
        send(8'h0F, -1, 0, 0);
        send(8'hF0, -1, 0, 0);
        @(negedge clk); rx_on = 0;
        @(negedge clk); rx_on = 1;
        chk(ovr_full == 0 && err_sts == 3'b100, "R9 stall cleared, status kept", {ovr_full, err_sts}, 4);
        w1c(3'b111);

        for (int it = 0; it < 300; it++) begin
            int c;
            c = int'($urandom_range(0, 5));
            irq_en = 3'($urandom);
            case (c)
                0, 1: send(W'($urandom), ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, W - 1)) : -1,
                           int'($urandom_range(0, 2)), 1'($urandom));
                2: rd_buf(v);
                3: w1c(3'($urandom));
                4: noise(int'($urandom_range(1, 5)));
                default: begin
                    @(negedge clk); rx_on = ($urandom_range(0, 7) != 0);
                    @(negedge clk); rx_on = 1;
                end
            endcase
        end

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule